// File: doc/BRIEF.md
# Receive Queue with Per-Character Error Tags and Line Status

This block stores received serial characters in a parameterised queue (64 entries by default). Every entry keeps its own parity, framing and break tags beside its data byte. From the stored state it derives the receive half of a line status byte and drives a line-status interrupt. A deserialiser upstream hands it one character per completion strobe. A host reads characters through a data-read strobe and reads the status byte through a status-read strobe.

The error-type bits describe only the character that the next data read will return. A separate summary bit says whether any errored character is still queued. The interrupt is raised as soon as an errored character arrives. If software has acknowledged it by reading status, the interrupt is raised again when that character reaches the head of the queue. With the queue disabled, the block acts as a single holding register.

Top module: `rx_status_queue`

## Requirements
- R1: Status bit 0 is 1 whenever at least one character is stored and 0 when none is. This holds with the queue enabled and with it disabled.
- R2: With `q_enable`=1 the queue holds up to DEPTH (64) characters and returns them in arrival order. With `q_enable`=0 it holds at most one character.
- R3: A character that arrives while the queue is full, with no data read in the same cycle, is discarded. It leaves the stored characters untouched and sets status bit 1 (overrun).
- R4: A status read clears status bit 1. If a new overrun happens in the same cycle as the status read, bit 1 stays set.
- R5: Status bits 2 (parity), 3 (framing) and 4 (break) show the tags of the head character only. They read 0 when the head is clean or the queue is empty. Bits 5 and 6 always read 0.
- R6: Status bit 7 is 1 while at least one stored character carries any error tag. It returns to 0 once the last such character has been read.
- R7: Storing an errored character raises the interrupt in the next cycle, even when clean characters are queued ahead of it. An overrun also raises it.
- R8: After a status read has cleared the interrupt, a data read that makes an errored character the new head raises the interrupt again.
- R9: A status read clears the pending interrupt. A raising event in the same cycle takes precedence over the clear.
- R10: `ls_irq` stays 0 while `ls_irq_en` is 0, and `ls_irq_en` powers up as 0 in any system reset. A condition recorded while the enable was low appears on `ls_irq` once the enable is set.
- R11: A data read with the queue empty leaves `rd_data` at its last value and moves no pointer. The next stored character is the next one returned.
- R12: `rd_data` updates one cycle after an accepted data read. On a full queue, a character arrival and a data read in the same cycle are both accepted and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid | input | 1 | One-cycle strobe: a character has completed |
| char_data | input | 8 | Received character |
| char_perr | input | 1 | Parity error tag of the character |
| char_ferr | input | 1 | Framing error tag of the character |
| char_brk | input | 1 | Break tag of the character |
| q_enable | input | 1 | 1: multi-entry queue, 0: single holding register |
| data_rd | input | 1 | Host read strobe for the data register |
| status_rd | input | 1 | Host read strobe for the status register |
| ls_irq_en | input | 1 | Line-status interrupt enable |
| rd_data | output | 8 | Last character read out |
| status | output | 8 | Receive line status byte |
| ls_irq | output | 1 | Line-status interrupt |

## Verification
Two groups of functions can land in the same clock. The first is a character arrival together with a data read on a full queue. The bench drives both strobes on one edge and expects no overrun, full occupancy kept, and the new character returned last. The second is an event that sets the overrun flag or the interrupt together with the status read that clears it. The bench drives the status strobe in the same cycle as an overrun or an errored arrival and expects both flags still set afterwards. It then confirms that a plain status read clears them.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef struct packed {
      logic brk;
      logic ferr;
      logic perr;
   } rx_tag_t;

   localparam int unsigned ST_AVAIL = 0;
   localparam int unsigned ST_OVR   = 1;
   localparam int unsigned ST_PERR  = 2;
   localparam int unsigned ST_FERR  = 3;
   localparam int unsigned ST_BRK   = 4;
   localparam int unsigned ST_ANYER = 7;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH    = 64,
   parameter int unsigned DW       = 8,
   parameter bit          ERR_SCAN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          q_enable,
   input  logic          push_req,
   input  logic [DW-1:0] push_data,
   input  rx_tag_t       push_tag,
   input  logic          pop_req,
   output logic          empty,
   output logic          full,
   output logic          push_ok,
   output logic          pop_ok,
   output logic          overrun_ev,
   output logic [DW-1:0] head_data,
   output rx_tag_t       head_tag,
   output logic          next_head_err,
   output logic          err_any
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = AW + 1;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("rxq_store: DEPTH must be a power of two >= 2");
      assert (DW >= 1) else $error("rxq_store: DW must be >= 1");
   end

   logic [DW-1:0] mem_data [DEPTH];
   rx_tag_t       mem_tag  [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr, rd_nxt;
   logic [CW-1:0] count, cap;

   assign cap      = q_enable ? CW'(DEPTH) : CW'(1);
   assign empty    = (count == '0);
   assign full     = (count >= cap);
   assign pop_ok   = pop_req & ~empty;
   assign push_ok  = push_req & (~full | pop_ok);
   assign overrun_ev = push_req & ~push_ok;
   assign rd_nxt   = AW'(rd_ptr + 1'b1);

   assign head_data = mem_data[rd_ptr];
   assign head_tag  = empty ? rx_tag_t'('0) : mem_tag[rd_ptr];

   always_comb begin
      if (count > CW'(1))
         next_head_err = |mem_tag[rd_nxt];
      else
         next_head_err = push_ok & (|push_tag);
   end

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem_data[wr_ptr] <= push_data;
         mem_tag[wr_ptr]  <= push_tag;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= AW'(wr_ptr + 1'b1);
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   generate
      if (ERR_SCAN) begin : g_scan
         logic [DEPTH-1:0] err_vec;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               err_vec <= '0;
            end else begin
               if (pop_ok)  err_vec[rd_ptr] <= 1'b0;
               if (push_ok) err_vec[wr_ptr] <= |push_tag;
            end
         end
         assign err_any = |err_vec;
      end else begin : g_count
         logic [CW-1:0] err_cnt;
         logic          inc, dec;
         assign inc = push_ok & (|push_tag);
         assign dec = pop_ok & (|head_tag);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               err_cnt <= '0;
            else if (inc & ~dec)
               err_cnt <= err_cnt + 1'b1;
            else if (dec & ~inc)
               err_cnt <= err_cnt - 1'b1;
         end
         assign err_any = (err_cnt != '0);
      end
   endgenerate

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R11
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req & empty & ~push_req) |=> empty);

   // R3
   discard_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_ev & ~pop_req) |=> $stable(count));

endmodule

// File: rtl/rxq_lsr.sv
module rxq_lsr
   import rxq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    empty,
   input  rx_tag_t head_tag,
   input  logic    err_any,
   input  logic    push_ok,
   input  logic    push_err,
   input  logic    pop_ok,
   input  logic    next_head_err,
   input  logic    overrun_ev,
   input  logic    status_rd,
   input  logic    irq_en,
   output logic [7:0] status,
   output logic    irq
);

   logic ovr_q, pend_q, raise;

   assign raise = (push_ok & push_err) | overrun_ev | (pop_ok & next_head_err);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (overrun_ev)     ovr_q <= 1'b1;
         else if (status_rd) ovr_q <= 1'b0;
         if (raise)          pend_q <= 1'b1;
         else if (status_rd) pend_q <= 1'b0;
      end
   end

   always_comb begin
      status           = '0;
      status[ST_AVAIL] = ~empty;
      status[ST_OVR]   = ovr_q;
      status[ST_PERR]  = head_tag.perr;
      status[ST_FERR]  = head_tag.ferr;
      status[ST_BRK]   = head_tag.brk;
      status[ST_ANYER] = err_any;
   end

   assign irq = irq_en & pend_q;

   // R5
   head_implies_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status[ST_ANYER] |-> (status[4:2] == 3'b000));

   // R7
   arrive_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok & push_err) |=> pend_q);

   // R8
   rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok & next_head_err) |=> (pend_q && status[4:2] != 3'b000));

endmodule

// File: rtl/rx_status_queue.sv
module rx_status_queue
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH    = 64,
   parameter int unsigned DW       = 8,
   parameter bit          ERR_SCAN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          char_valid,
   input  logic [DW-1:0] char_data,
   input  logic          char_perr,
   input  logic          char_ferr,
   input  logic          char_brk,
   input  logic          q_enable,
   input  logic          data_rd,
   input  logic          status_rd,
   input  logic          ls_irq_en,
   output logic [DW-1:0] rd_data,
   output logic [7:0]    status,
   output logic          ls_irq
);

   rx_tag_t       in_tag, head_tag;
   logic          empty, full, push_ok, pop_ok, overrun_ev;
   logic          next_head_err, err_any;
   logic [DW-1:0] head_data;

   assign in_tag = '{brk: char_brk, ferr: char_ferr, perr: char_perr};

   rxq_store #(.DEPTH(DEPTH), .DW(DW), .ERR_SCAN(ERR_SCAN)) u_store (
      .clk           (clk),
      .rst_n         (rst_n),
      .q_enable      (q_enable),
      .push_req      (char_valid),
      .push_data     (char_data),
      .push_tag      (in_tag),
      .pop_req       (data_rd),
      .empty         (empty),
      .full          (full),
      .push_ok       (push_ok),
      .pop_ok        (pop_ok),
      .overrun_ev    (overrun_ev),
      .head_data     (head_data),
      .head_tag      (head_tag),
      .next_head_err (next_head_err),
      .err_any       (err_any)
   );

   rxq_lsr u_lsr (
      .clk           (clk),
      .rst_n         (rst_n),
      .empty         (empty),
      .head_tag      (head_tag),
      .err_any       (err_any),
      .push_ok       (push_ok),
      .push_err      (|in_tag),
      .pop_ok        (pop_ok),
      .next_head_err (next_head_err),
      .overrun_ev    (overrun_ev),
      .status_rd     (status_rd),
      .irq_en        (ls_irq_en),
      .status        (status),
      .irq           (ls_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (pop_ok)
         rd_data <= head_data;
   end

   // R11
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd & ~status[ST_AVAIL]) |=> $stable(rd_data));

   // R3
   ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid & full & ~data_rd) |=> status[ST_OVR]);

   // R9
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd & ~char_valid & ~data_rd) |=> !ls_irq);

   // R12
   full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid & data_rd & full & ~status[ST_OVR] & ~status_rd) |=> !status[ST_OVR]);

endmodule

// File: tb/rx_status_queue_bench.sv
module rx_status_queue_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       char_valid = 1'b0;
   logic [7:0] char_data = '0;
   logic       char_perr = 1'b0, char_ferr = 1'b0, char_brk = 1'b0;
   logic       q_enable = 1'b1;
   logic       data_rd = 1'b0, status_rd = 1'b0, ls_irq_en = 1'b0;
   logic [7:0] rd_data, status;
   logic       ls_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   rx_status_queue u_rx_status_queue (
      .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
      .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
      .q_enable(q_enable), .data_rd(data_rd), .status_rd(status_rd),
      .ls_irq_en(ls_irq_en), .rd_data(rd_data), .status(status), .ls_irq(ls_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one clock of stimulus; returns at the next falling edge
   task automatic step(input logic cv, input logic [7:0] d, input logic [2:0] bfp,
                       input logic drd, input logic srd);
      @(negedge clk);
      char_valid = cv; char_data = d;
      {char_brk, char_ferr, char_perr} = bfp;
      data_rd = drd; status_rd = srd;
      @(negedge clk);
      char_valid = 1'b0; data_rd = 1'b0; status_rd = 1'b0;
      {char_brk, char_ferr, char_perr} = 3'b000;
   endtask

   task automatic push(input logic [7:0] d, input logic [2:0] bfp);
      step(1'b1, d, bfp, 1'b0, 1'b0);
   endtask

   task automatic pop();
      step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
   endtask

   task automatic srd();
      step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
   endtask

   task automatic t_reset();
      check("R1 reset status", status, 8'h00);
      check("R10 reset irq", ls_irq, 0);
      check("R12 reset rd_data", rd_data, 8'h00);
   endtask

   task automatic t_order_and_empty();
      ls_irq_en = 1'b0;
      push(8'h11, 3'b000); push(8'h22, 3'b000); push(8'h33, 3'b000);
      check("R1 data available", status, 8'h01);
      pop(); check("R12 first out", rd_data, 8'h11);
      pop(); check("R2 order", rd_data, 8'h22);
      pop(); check("R2 order last", rd_data, 8'h33);
      check("R1 empty", status, 8'h00);
      pop(); check("R11 empty read holds", rd_data, 8'h33);
      push(8'h44, 3'b000); pop();
      check("R11 pointers unchanged", rd_data, 8'h44);
   endtask

   task automatic t_head_errors();
      ls_irq_en = 1'b1;
      push(8'h55, 3'b000);
      push(8'hAA, 3'b001);
      check("R7 irq on errored arrival", ls_irq, 1);
      check("R5 R6 clean head errored behind", status, 8'h81);
      srd();
      check("R9 status read clears irq", ls_irq, 0);
      pop();
      check("R8 irq re-raised at head", ls_irq, 1);
      check("R5 parity bit at head", status, 8'h85);
      srd(); pop();
      check("R6 summary clears", status, 8'h00);
      check("R12 errored byte out", rd_data, 8'hAA);
      push(8'h01, 3'b010);
      check("R5 framing bit", status, 8'h89);
      srd(); pop();
      push(8'h02, 3'b100);
      check("R5 break bit", status, 8'h91);
      srd(); pop();
      check("R9 drained irq", ls_irq, 0);
   endtask

   task automatic t_irq_gate();
      ls_irq_en = 1'b0;
      push(8'h66, 3'b001);
      check("R10 irq gated", ls_irq, 0);
      @(negedge clk); ls_irq_en = 1'b1; #1;
      check("R10 pending shown on enable", ls_irq, 1);
      srd(); pop();
      check("R9 cleared", ls_irq, 0);
   endtask

   task automatic t_overrun();
      for (int i = 0; i < 64; i++) push(8'(i), 3'b000);
      check("R2 full no overrun", status, 8'h01);
      push(8'hEE, 3'b000);
      check("R3 overrun bit", status, 8'h03);
      check("R7 irq on overrun", ls_irq, 1);
      srd();
      check("R4 overrun cleared", status, 8'h01);
      begin
         int bad = 0;
         for (int i = 0; i < 64; i++) begin
            pop();
            if (rd_data !== 8'(i)) bad++;
         end
         check("R3 R2 contents preserved", bad, 0);
      end
      check("R3 discarded byte absent", status, 8'h00);
   endtask

   task automatic t_same_cycle();
      for (int i = 0; i < 64; i++) push(8'(i + 8'h80), 3'b000);
      step(1'b1, 8'h7E, 3'b000, 1'b1, 1'b0);
      check("R12 push and pop on full", status, 8'h01);
      check("R12 popped head", rd_data, 8'h80);
      step(1'b1, 8'h7F, 3'b000, 1'b0, 1'b1);
      check("R4 overrun set beats clear", status[1], 1);
      srd();
      check("R4 plain clear", status[1], 0);
      begin
         int bad = 0;
         for (int i = 1; i < 64; i++) begin
            pop();
            if (rd_data !== 8'(i + 8'h80)) bad++;
         end
         check("R12 queue order kept", bad, 0);
         pop();
         check("R12 new byte last", rd_data, 8'h7E);
      end
      step(1'b1, 8'h31, 3'b001, 1'b0, 1'b1);
      check("R9 raise beats clear", ls_irq, 1);
      srd(); pop();
   endtask

   task automatic t_holding();
      q_enable = 1'b0;
      push(8'h10, 3'b000);
      check("R1 holding has data", status[0], 1);
      push(8'h20, 3'b000);
      check("R2 holding one entry overrun", status[1], 1);
      pop();
      check("R3 holding kept first", rd_data, 8'h10);
      check("R1 holding empty", status[0], 0);
      srd();
      q_enable = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_order_and_empty();
      t_head_errors();
      t_irq_gate();
      t_overrun();
      t_same_cycle();
      t_holding();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule